// File: doc/BRIEF.md
# Speculative Load Address Guard

This block keeps a small, fully associative record of loads that were executed early, ahead of stores that might write the same memory. When such an early load issues, it writes an entry holding the tag of its destination register and the block address it read. Every store that passes by is compared against all live entries at the same time. Any entry whose 8-byte block matches the store is dropped, because the value that load returned may now be stale.

Later, at the point where the load would originally have executed, a verify operation names the register tag. One cycle afterwards the block answers. A clear answer means the early value is still good, and the entry is then released. A fixup answer means the entry was killed by a store, was evicted, or was never written, so the caller must issue the load again. Each register tag owns at most one entry. When the table is full, slots are reused in round-robin order.

Top module: `ld_addr_guard`

## Requirements
- R1: After rst_ni is released, rsp_valid_o is 0 and every entry is empty, so a verify of any tag answers fixup (rsp_fixup_o = 1). An entry written before a reset is gone after it.
- R2: A verify of a tag that was written earlier and has not been removed answers rsp_fixup_o = 0.
- R3: A verify of a tag that was never written answers rsp_fixup_o = 1.
- R4: A store kills an entry when store_addr_i[31:3] equals the entry's address bits [31:3]; bits [2:0] take no part in the compare. A store to any other block leaves the entry alive.
- R5: One store kills every live entry in the matching block in the same cycle, whatever their tags.
- R6: rsp_valid_o is 1 in exactly the cycle after a cycle with check_valid_i = 1, and 0 otherwise.
- R7: A verify that answers clear also releases the entry, so a second verify of the same tag answers fixup.
- R8: Writing a tag that already owns an entry overwrites that entry's address in place. Stores then match only the new address, and the tag never has two entries.
- R9: The table has 8 slots. After reset, writes fill free slots from slot 0 upward. When no slot is free and the tag is new, the write evicts the slot under a round-robin pointer that starts at slot 0 and advances by one per eviction.
- R10: When a write and a store to the same block fall in one cycle, the new entry survives and every other matching entry is killed.
- R11: A verify is judged on the table as it stood at the start of its cycle. A store or a write in the same cycle does not change that answer. A write to the verified tag in that cycle takes priority over the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Early load writes an entry |
| alloc_tag_i | input | 7 | Destination register tag of the early load |
| alloc_addr_i | input | 32 | Address read by the early load |
| store_valid_i | input | 1 | Store to snoop |
| store_addr_i | input | 32 | Store address |
| check_valid_i | input | 1 | Verify request |
| check_tag_i | input | 7 | Register tag to verify |
| rsp_valid_o | output | 1 | Verify answer valid (one cycle after request) |
| rsp_fixup_o | output | 1 | 1 = reload needed, 0 = early value good |

## Verification
The collision that matters most is a write and a store that land in the same cycle and name the same 8-byte block. The bench provokes it with an older entry already resident in that block, then issues the write of a second tag together with a store to that block. Verifying both tags afterwards must give fixup for the older one and clear for the new one. A verify issued alongside a store to its own entry is also exercised: it must still answer clear, which shows that the answer comes from the state held before the edge.

// File: rtl/ldg_pkg.sv
package ldg_pkg;
  localparam int unsigned DEF_ENTRIES = 8;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_TAG_W   = 7;
  localparam int unsigned DEF_OFS_W   = 3;
endpackage

// File: rtl/ldg_cam.sv
module ldg_cam #(
  parameter int unsigned N  = ldg_pkg::DEF_ENTRIES,
  parameter int unsigned KW = ldg_pkg::DEF_ADDR_W - ldg_pkg::DEF_OFS_W,
  parameter int unsigned TW = ldg_pkg::DEF_TAG_W
) (
  input  logic [N-1:0]         vld_i,
  input  logic [N-1:0][KW-1:0] key_i,
  input  logic [N-1:0][TW-1:0] tag_i,
  input  logic [KW-1:0]        st_key_i,
  input  logic [TW-1:0]        chk_tag_i,
  input  logic [TW-1:0]        al_tag_i,
  output logic [N-1:0]         st_hit_o,
  output logic [N-1:0]         chk_hit_o,
  output logic [N-1:0]         al_hit_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign st_hit_o[g]  = vld_i[g] && (key_i[g] == st_key_i);
    assign chk_hit_o[g] = vld_i[g] && (tag_i[g] == chk_tag_i);
    assign al_hit_o[g]  = vld_i[g] && (tag_i[g] == al_tag_i);
  end
endmodule

// File: rtl/ldg_victim.sv
module ldg_victim #(
  parameter int unsigned N = ldg_pkg::DEF_ENTRIES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         alloc_i,
  input  logic [N-1:0] vld_i,
  input  logic [N-1:0] hit_i,
  output logic [N-1:0] sel_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr_q;
  logic [N-1:0]  free_oh, rr_oh;
  logic          any_hit, any_free;

  assign any_hit  = |hit_i;
  assign any_free = ~&vld_i;

  always_comb begin
    free_oh = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        free_oh    = '0;
        free_oh[i] = 1'b1;
      end
    end
    rr_oh        = '0;
    rr_oh[ptr_q] = 1'b1;
    if (any_hit)       sel_o = hit_i;
    else if (any_free) sel_o = free_oh;
    else               sel_o = rr_oh;
  end

  // pointer moves only when a live slot is displaced
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (alloc_i && !any_hit && !any_free)
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end
endmodule

// File: rtl/ld_addr_guard.sv
module ld_addr_guard #(
  parameter int unsigned N    = ldg_pkg::DEF_ENTRIES,
  parameter int unsigned AW   = ldg_pkg::DEF_ADDR_W,
  parameter int unsigned TW   = ldg_pkg::DEF_TAG_W,
  parameter int unsigned OW   = ldg_pkg::DEF_OFS_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          alloc_valid_i,
  input  logic [TW-1:0] alloc_tag_i,
  input  logic [AW-1:0] alloc_addr_i,
  input  logic          store_valid_i,
  input  logic [AW-1:0] store_addr_i,
  input  logic          check_valid_i,
  input  logic [TW-1:0] check_tag_i,
  output logic          rsp_valid_o,
  output logic          rsp_fixup_o
);
  localparam int unsigned KW = AW - OW;

  logic [N-1:0]         vld_q;
  logic [N-1:0][KW-1:0] key_q;
  logic [N-1:0][TW-1:0] tag_q;
  logic [N-1:0]         st_hit, chk_hit, al_hit, sel;

  ldg_cam #(.N(N), .KW(KW), .TW(TW)) u_cam (
    .vld_i     (vld_q),
    .key_i     (key_q),
    .tag_i     (tag_q),
    .st_key_i  (store_addr_i[AW-1:OW]),
    .chk_tag_i (check_tag_i),
    .al_tag_i  (alloc_tag_i),
    .st_hit_o  (st_hit),
    .chk_hit_o (chk_hit),
    .al_hit_o  (al_hit)
  );

  ldg_victim #(.N(N)) u_victim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc_valid_i),
    .vld_i   (vld_q),
    .hit_i   (al_hit),
    .sel_o   (sel)
  );

  // write beats both store kill and verify release
  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        key_q[g] <= '0;
        tag_q[g] <= '0;
      end else if (alloc_valid_i && sel[g]) begin
        vld_q[g] <= 1'b1;
        key_q[g] <= alloc_addr_i[AW-1:OW];
        tag_q[g] <= alloc_tag_i;
      end else if ((store_valid_i && st_hit[g]) || (check_valid_i && chk_hit[g])) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fixup_o <= 1'b0;
    end else begin
      rsp_valid_o <= check_valid_i;
      rsp_fixup_o <= check_valid_i && !(|chk_hit);
    end
  end
endmodule

// File: rtl/ldg_checker.sv
module ldg_checker #(
  parameter int unsigned N  = 8,
  parameter int unsigned AW = 32,
  parameter int unsigned TW = 7,
  parameter int unsigned OW = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    alloc_valid_i,
  input logic [TW-1:0]           alloc_tag_i,
  input logic                    store_valid_i,
  input logic [AW-1:0]           store_addr_i,
  input logic                    check_valid_i,
  input logic [TW-1:0]           check_tag_i,
  input logic                    rsp_valid_o,
  input logic                    rsp_fixup_o,
  input logic [N-1:0]            vld_q,
  input logic [N-1:0][AW-OW-1:0] key_q,
  input logic [N-1:0][TW-1:0]    tag_q
);
  logic              dup, chk_pres, al_pres, st_pres;
  logic              al_v_d, st_v_d;
  logic [TW-1:0]     al_tag_d;
  logic [AW-OW-1:0]  st_key_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      al_v_d <= 1'b0; st_v_d <= 1'b0; al_tag_d <= '0; st_key_d <= '0;
    end else begin
      al_v_d   <= alloc_valid_i;
      al_tag_d <= alloc_tag_i;
      st_v_d   <= store_valid_i && !alloc_valid_i;
      st_key_d <= store_addr_i[AW-1:OW];
    end
  end

  always_comb begin
    dup = 1'b0; chk_pres = 1'b0; al_pres = 1'b0; st_pres = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && tag_q[i] == check_tag_i) chk_pres = 1'b1;
      if (vld_q[i] && tag_q[i] == al_tag_d)    al_pres  = 1'b1;
      if (vld_q[i] && key_q[i] == st_key_d)    st_pres  = 1'b1;
      for (int j = i + 1; j < N; j++)
        if (vld_q[i] && vld_q[j] && tag_q[i] == tag_q[j]) dup = 1'b1;
    end
  end

  a_r6_rsp_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_valid_i |=> rsp_valid_o);
  a_r6_rsp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !check_valid_i |=> !rsp_valid_o);
  a_r3_fixup_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_valid_i |=> (rsp_fixup_o == !$past(chk_pres)));
  a_r8_tag_unique: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dup);
  a_r2_alloc_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    al_v_d |-> al_pres);
  a_r4_store_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_v_d |-> !st_pres);
endmodule

bind ld_addr_guard ldg_checker #(.N(N), .AW(AW), .TW(TW), .OW(OW)) u_ldg_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alloc_valid_i (alloc_valid_i),
  .alloc_tag_i   (alloc_tag_i),
  .store_valid_i (store_valid_i),
  .store_addr_i  (store_addr_i),
  .check_valid_i (check_valid_i),
  .check_tag_i   (check_tag_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_fixup_o   (rsp_fixup_o),
  .vld_q         (vld_q),
  .key_q         (key_q),
  .tag_q         (tag_q)
);

// File: tb/ld_addr_guard_test.sv
module ld_addr_guard_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_valid_i = 1'b0;
  logic [6:0]  alloc_tag_i = '0;
  logic [31:0] alloc_addr_i = '0;
  logic        store_valid_i = 1'b0;
  logic [31:0] store_addr_i = '0;
  logic        check_valid_i = 1'b0;
  logic [6:0]  check_tag_i = '0;
  logic        rsp_valid_o, rsp_fixup_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  ld_addr_guard uut (.*);

  typedef struct packed {
    logic av; logic [6:0] at; logic [31:0] aa;
    logic sv; logic [31:0] sa;
    logic cv; logic [6:0] ct;
    logic ef; logic [3:0] rq;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd5,  1'b1, 4'd3},  // R3 never written
    '{1'b1, 7'd5,  32'h100, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd6},  // R6 idle
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd5,  1'b0, 4'd2},  // R2 present
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd5,  1'b1, 4'd7},  // R7 released
    '{1'b1, 7'd6,  32'h200, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd6},
    '{1'b0, 7'd0,  32'h0,   1'b1, 32'h208, 1'b0, 7'd0,  1'b0, 4'd4},
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd6,  1'b0, 4'd4},  // R4 other block
    '{1'b1, 7'd6,  32'h200, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd4},
    '{1'b0, 7'd0,  32'h0,   1'b1, 32'h205, 1'b0, 7'd0,  1'b0, 4'd4},
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd6,  1'b1, 4'd4},  // R4 low bits ignored
    '{1'b1, 7'd1,  32'h300, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd5},
    '{1'b1, 7'd2,  32'h304, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd5},
    '{1'b0, 7'd0,  32'h0,   1'b1, 32'h300, 1'b0, 7'd0,  1'b0, 4'd5},
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd1,  1'b1, 4'd5},  // R5
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd2,  1'b1, 4'd5},  // R5
    '{1'b1, 7'd3,  32'h400, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd8},
    '{1'b1, 7'd3,  32'h500, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd8},
    '{1'b0, 7'd0,  32'h0,   1'b1, 32'h400, 1'b0, 7'd0,  1'b0, 4'd8},
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd3,  1'b0, 4'd8},  // R8 old address dead
    '{1'b1, 7'd3,  32'h500, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd8},
    '{1'b0, 7'd0,  32'h0,   1'b1, 32'h500, 1'b0, 7'd0,  1'b0, 4'd8},
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd3,  1'b1, 4'd8},  // R8 new address live
    '{1'b1, 7'd4,  32'h600, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd10},
    '{1'b1, 7'd9,  32'h600, 1'b1, 32'h600, 1'b0, 7'd0,  1'b0, 4'd10},
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd4,  1'b1, 4'd10}, // R10 older killed
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd9,  1'b0, 4'd10}, // R10 write wins
    '{1'b1, 7'd10, 32'h700, 1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd11},
    '{1'b0, 7'd0,  32'h0,   1'b1, 32'h700, 1'b1, 7'd10, 1'b0, 4'd11}, // R11 store same cycle
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b0, 7'd0,  1'b0, 4'd6},
    '{1'b1, 7'd11, 32'h800, 1'b0, 32'h0,   1'b1, 7'd11, 1'b1, 4'd11}, // R11 write same cycle
    '{1'b0, 7'd0,  32'h0,   1'b0, 32'h0,   1'b1, 7'd11, 1'b0, 4'd11}
  };

  task automatic expect_bit(input logic act, input logic exp, input int rq, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", rq, what, act, exp);
    end
  endtask

  task automatic step(input vec_t v);
    alloc_valid_i = v.av; alloc_tag_i = v.at; alloc_addr_i = v.aa;
    store_valid_i = v.sv; store_addr_i = v.sa;
    check_valid_i = v.cv; check_tag_i = v.ct;
    @(posedge clk_i); #1;
    expect_bit(rsp_valid_o, v.cv, 6, "rsp_valid");
    if (v.cv) expect_bit(rsp_fixup_o, v.ef, int'(v.rq), "rsp_fixup");
    alloc_valid_i = 1'b0; store_valid_i = 1'b0; check_valid_i = 1'b0;
  endtask

  task automatic do_alloc(input logic [6:0] t, input logic [31:0] a);
    step('{1'b1, t, a, 1'b0, 32'h0, 1'b0, 7'd0, 1'b0, 4'd9});
  endtask

  task automatic do_check(input logic [6:0] t, input logic ef, input logic [3:0] rq);
    step('{1'b0, 7'd0, 32'h0, 1'b0, 32'h0, 1'b1, t, ef, rq});
  endtask

  task automatic do_reset();
    #1 rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    #1 rst_ni = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL R6 watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    expect_bit(rsp_valid_o, 1'b0, 1, "rsp_valid after reset"); // R1

    for (int i = 0; i < NV; i++) step(VECS[i]);

    // R1: reset wipes a live entry
    do_alloc(7'd40, 32'h900);
    do_reset();
    expect_bit(rsp_valid_o, 1'b0, 1, "rsp_valid after reset");
    do_check(7'd40, 1'b1, 4'd1);

    // R9: fill slots 0..7, then two evictions hit slots 0 and 1
    for (int k = 0; k < 8; k++) do_alloc(7'(20 + k), 32'h1000 + 32'(k * 8));
    do_alloc(7'd28, 32'h2000);
    do_alloc(7'd29, 32'h2008);
    do_check(7'd20, 1'b1, 4'd9);
    do_check(7'd21, 1'b1, 4'd9);
    do_check(7'd22, 1'b0, 4'd9);
    do_check(7'd27, 1'b0, 4'd9);
    do_check(7'd28, 1'b0, 4'd9);
    do_check(7'd29, 1'b0, 4'd9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule